// File: doc/BRIEF.md
# Bootstrap Processor Election

After reset, a multiprocessor system must pick exactly one agent to boot the machine. This block models that choice for N logical agents. Each agent gets a unique identifier on its ID input, and its arbitration priority comes from that value: a larger ID means a higher priority. All agents start their built-in self-tests together. Each agent reports completion with a single-cycle done pulse, which carries a pass or fail result.

The election waits for two conditions. Every agent must have reported its self-test result, and a shared bus-ready line, which toggles during start-up, must have held one level for `QUIET_CYCLES` consecutive clocks. Each healthy agent then requests the bus for a no-op special cycle. A largest-ID priority arbiter grants one of them. The winner sets its bootstrap flag and starts fetching at the reset vector 0xFFFFFFF0. Every other agent, including any agent that failed its self-test, keeps its flag clear and waits for a startup message. Results hold until the next reset.

The per-agent state is brought out as a packed 3-bit field per agent. Integration logic can then see which agent is the bootstrap processor and which are application processors.

Top module: `bsp_election`

## Requirements
- R1: While `rst_n` is low, every agent state field reads 0 (reset), all bootstrap flags are 0, `fetch_valid_o` is 0 and `fetch_addr_o` is 0.
- R2: The state encoding is 0=reset, 1=self-test, 2=wait-quiet, 3=arbitrate, 4=bootstrap-run and 5=wait-startup. Agent i occupies bits [3i+2:3i]. One clock after reset is released every agent is in state 1. Agents stay in state 1 until every agent has pulsed its done bit, whatever any pass or fail result says.
- R3: The bus-ready line counts as quiet once it has been sampled at one level for `QUIET_CYCLES` consecutive clocks after its last change. Any change restarts the count, and agents do not leave state 2 until the line is quiet.
- R4: Only agents whose self-test passed (fail bit 0 when done was pulsed) request arbitration. The grant goes to the requester with the numerically largest ID, and an agent that failed never wins.
- R5: When at least one agent passed, exactly one bootstrap flag is set after arbitration. It belongs to the winning agent, whose state becomes 4.
- R6: Every agent that did not win, whether it lost or failed, ends in state 5 with its bootstrap flag clear.
- R7: `fetch_valid_o` is 1 and `fetch_addr_o` is 0xFFFFFFF0 exactly when a bootstrap flag is set, starting the clock after arbitration. Otherwise both are 0.
- R8: Once the election is over, states, flags and fetch outputs hold until reset, whatever the bus-ready line, done or fail inputs do.
- R9: If every agent failed its self-test, no flag is set, `fetch_valid_o` stays 0 and every agent ends in state 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| agent_ids_i | input | N_AGENTS*ID_W | Unique ID per agent, agent i in bits [ID_W*i +: ID_W] |
| bist_done_i | input | N_AGENTS | Self-test completion pulse per agent |
| bist_fail_i | input | N_AGENTS | Self-test failure, sampled with the done pulse |
| bus_ready_i | input | 1 | Shared bus-ready line, toggling during start-up |
| agent_state_o | output | 3*N_AGENTS | Packed per-agent state, encoding as in R2 |
| bsp_flag_o | output | N_AGENTS | Persistent bootstrap-processor flag per agent |
| fetch_valid_o | output | 1 | A bootstrap processor is fetching |
| fetch_addr_o | output | 32 | Fetch address, the reset vector while valid |

## Verification
Every agent's state leaves the block on each clock. A wrong transition therefore shows on `agent_state_o` at the first sample after the edge that caused it, for example an early move out of self-test or a premature arbitration during a glitch. Errors in grant logic or flag latching show one clock after arbitration as a wrong or duplicate bootstrap flag, an agent with a set flag but the wrong state, or a fetch output out of step with the flags. Corruption after the election shows as any change on those outputs before the next reset.

// File: rtl/bsp_election_pkg.sv
package bsp_election_pkg;

  typedef enum logic [2:0] {
    ST_RESET      = 3'd0,
    ST_SELFTEST   = 3'd1,
    ST_WAIT_QUIET = 3'd2,
    ST_ARB        = 3'd3,
    ST_BOOT       = 3'd4,
    ST_AP_WAIT    = 3'd5
  } agent_state_e;

  localparam logic [31:0] BOOT_VECTOR = 32'hFFFF_FFF0;

  // Terminal states hold until reset.
  function automatic logic is_terminal(agent_state_e s);
    return (s == ST_BOOT) || (s == ST_AP_WAIT);
  endfunction

endpackage

// File: rtl/bsp_quiet_detect.sv
module bsp_quiet_detect #(
  parameter int QUIET_CYCLES = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic change_o,
  output logic quiet_o
);
  localparam int CW = $clog2(QUIET_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(QUIET_CYCLES);

  logic          prev_q;
  logic [CW-1:0] run_q;

  assign change_o = (line_i != prev_q);
  assign quiet_o  = (run_q == LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      run_q  <= '0;
    end else begin
      prev_q <= line_i;
      if (change_o)
        run_q <= '0;
      else if (run_q != LIMIT)
        run_q <= run_q + 1'b1;
    end
  end
endmodule

// File: rtl/bsp_prio_arbiter.sv
module bsp_prio_arbiter #(
  parameter int N_AGENTS = 4,
  parameter int ID_W     = 8
) (
  input  logic [N_AGENTS*ID_W-1:0] ids_i,
  input  logic [N_AGENTS-1:0]      req_i,
  output logic [N_AGENTS-1:0]      grant_o,
  output logic                     grant_any_o
);
  // Priority is the ID itself: larger number, higher priority.
  function automatic logic [ID_W-1:0] prio_of(logic [ID_W-1:0] id);
    return id;
  endfunction

  logic [ID_W-1:0] best_prio;
  logic            found;

  always_comb begin
    best_prio = '0;
    found     = 1'b0;
    grant_o   = '0;
    for (int i = 0; i < N_AGENTS; i++) begin
      // Strictly greater keeps the lowest index on a tie.
      if (req_i[i] && (!found || prio_of(ids_i[i*ID_W +: ID_W]) > best_prio)) begin
        best_prio = prio_of(ids_i[i*ID_W +: ID_W]);
        found     = 1'b1;
        grant_o   = '0;
        grant_o[i] = 1'b1;
      end
    end
    grant_any_o = found;
  end
endmodule

// File: rtl/bsp_agent_fsm.sv
module bsp_agent_fsm
  import bsp_election_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bist_done_i,
  input  logic         bist_fail_i,
  input  logic         all_done_i,
  input  logic         quiet_i,
  input  logic         grant_i,
  output agent_state_e state_o,
  output logic         req_o,
  output logic         done_o,
  output logic         fail_o,
  output logic         bsp_flag_o
);
  agent_state_e st_q, st_d;
  logic         done_q, fail_q, flag_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_RESET:      st_d = ST_SELFTEST;
      ST_SELFTEST:   if (all_done_i) st_d = ST_WAIT_QUIET;
      ST_WAIT_QUIET: if (quiet_i)    st_d = ST_ARB;
      ST_ARB:        st_d = grant_i ? ST_BOOT : ST_AP_WAIT;
      default:       st_d = st_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_RESET;
      done_q <= 1'b0;
      fail_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (bist_done_i && !done_q) begin
        done_q <= 1'b1;
        fail_q <= bist_fail_i;
      end
      if (st_q == ST_ARB && grant_i)
        flag_q <= 1'b1;
    end
  end

  assign state_o    = st_q;
  assign req_o      = (st_q == ST_ARB) && !fail_q;
  assign done_o     = done_q;
  assign fail_o     = fail_q;
  assign bsp_flag_o = flag_q;
endmodule

// File: rtl/bsp_election.sv
module bsp_election
  import bsp_election_pkg::*;
#(
  parameter int N_AGENTS     = 4,
  parameter int ID_W         = 8,
  parameter int QUIET_CYCLES = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_AGENTS*ID_W-1:0] agent_ids_i,
  input  logic [N_AGENTS-1:0]      bist_done_i,
  input  logic [N_AGENTS-1:0]      bist_fail_i,
  input  logic                     bus_ready_i,
  output logic [3*N_AGENTS-1:0]    agent_state_o,
  output logic [N_AGENTS-1:0]      bsp_flag_o,
  output logic                     fetch_valid_o,
  output logic [31:0]              fetch_addr_o
);
  // Named internal events, observed by the bound checker.
  logic                line_change;
  logic                quiet;
  logic                all_done;
  logic                arb_any;
  logic                grant_any;
  logic [N_AGENTS-1:0] req_vec;
  logic [N_AGENTS-1:0] grant_vec;
  logic [N_AGENTS-1:0] done_vec;
  logic [N_AGENTS-1:0] fail_vec;
  logic [N_AGENTS-1:0] arb_vec;
  agent_state_e        st [N_AGENTS];

  bsp_quiet_detect #(.QUIET_CYCLES(QUIET_CYCLES)) u_quiet (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_i   (bus_ready_i),
    .change_o (line_change),
    .quiet_o  (quiet)
  );

  bsp_prio_arbiter #(.N_AGENTS(N_AGENTS), .ID_W(ID_W)) u_arb (
    .ids_i       (agent_ids_i),
    .req_i       (req_vec),
    .grant_o     (grant_vec),
    .grant_any_o (grant_any)
  );

  for (genvar i = 0; i < N_AGENTS; i++) begin : g_agent
    bsp_agent_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .bist_done_i (bist_done_i[i]),
      .bist_fail_i (bist_fail_i[i]),
      .all_done_i  (all_done),
      .quiet_i     (quiet),
      .grant_i     (grant_vec[i]),
      .state_o     (st[i]),
      .req_o       (req_vec[i]),
      .done_o      (done_vec[i]),
      .fail_o      (fail_vec[i]),
      .bsp_flag_o  (bsp_flag_o[i])
    );
    assign agent_state_o[3*i +: 3] = st[i];
    assign arb_vec[i] = (st[i] == ST_ARB);
  end

  assign all_done      = &done_vec;
  assign arb_any       = |arb_vec;
  assign fetch_valid_o = |bsp_flag_o;
  assign fetch_addr_o  = fetch_valid_o ? BOOT_VECTOR : 32'h0;
endmodule

module bsp_election_chk #(
  parameter int N_AGENTS = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic [N_AGENTS-1:0] bsp_flag_o,
  input logic [N_AGENTS-1:0] fail_vec,
  input logic                fetch_valid_o,
  input logic                bus_ready_i,
  input logic                quiet,
  input logic                all_done,
  input logic                arb_any,
  input logic                grant_any
);
  AST_BSP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bsp_flag_o)); // R5
  AST_ARB_AFTER_SELFTEST: assert property (@(posedge clk) disable iff (!rst_n)
    arb_any |-> all_done); // R2
  AST_ARB_AFTER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb_any) |-> $past(quiet)); // R3
  AST_CHANGE_CLEARS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ready_i != $past(bus_ready_i)) |=> !quiet); // R3
  AST_FAILED_NEVER_BSP: assert property (@(posedge clk) disable iff (!rst_n)
    (bsp_flag_o & fail_vec) == '0); // R4
  AST_GRANT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    grant_any |=> fetch_valid_o); // R5
  AST_FETCH_AFTER_ARB: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fetch_valid_o) |-> $past(arb_any)); // R7
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (|bsp_flag_o) |=> $stable(bsp_flag_o)); // R8
endmodule

bind bsp_election bsp_election_chk #(.N_AGENTS(N_AGENTS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bsp_flag_o    (bsp_flag_o),
  .fail_vec      (fail_vec),
  .fetch_valid_o (fetch_valid_o),
  .bus_ready_i   (bus_ready_i),
  .quiet         (quiet),
  .all_done      (all_done),
  .arb_any       (arb_any),
  .grant_any     (grant_any)
);

// File: tb/tb_bsp_election.sv
`timescale 1ns/100ps
module tb_bsp_election;
  localparam int N   = 4;
  localparam int IDW = 8;
  localparam int Q   = 6;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [N*IDW-1:0] ids = '0;
  logic [N-1:0]     bist_done = '0;
  logic [N-1:0]     bist_fail = '0;
  logic             bus_rdy = 1'b0;
  logic [3*N-1:0]   state;
  logic [N-1:0]     flags;
  logic             fvalid;
  logic [31:0]      faddr;

  int n_checks = 0;
  int n_fail   = 0;
  bit seen     = 1'b0;
  bit finished = 1'b0;
  int ids_arr [N];

  typedef struct { int win; logic [N-1:0] failm; } exp_t;
  exp_t sb_q [$];

  always #2.5 clk = ~clk;

  bsp_election #(.N_AGENTS(N), .ID_W(IDW), .QUIET_CYCLES(Q)) dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .agent_ids_i   (ids),
    .bist_done_i   (bist_done),
    .bist_fail_i   (bist_fail),
    .bus_ready_i   (bus_rdy),
    .agent_state_o (state),
    .bsp_flag_o    (flags),
    .fetch_valid_o (fvalid),
    .fetch_addr_o  (faddr)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] st_of(int i);
    return state[3*i +: 3];
  endfunction

  function automatic bit all_final();
    for (int i = 0; i < N; i++)
      if (st_of(i) != 3'd4 && st_of(i) != 3'd5) return 1'b0;
    return 1'b1;
  endfunction

  // Bench model of the winner: largest ID among passing agents.
  function automatic int exp_winner(logic [N-1:0] failm);
    int best = -1;
    for (int i = 0; i < N; i++)
      if (!failm[i] && (best < 0 || ids_arr[i] > ids_arr[best])) best = i;
    return best;
  endfunction

  task automatic set_ids(int a0, int a1, int a2, int a3);
    ids_arr[0] = a0; ids_arr[1] = a1; ids_arr[2] = a2; ids_arr[3] = a3;
    for (int i = 0; i < N; i++) ids[i*IDW +: IDW] = IDW'(ids_arr[i]);
  endtask

  task automatic push_exp(logic [N-1:0] failm);
    exp_t e;
    e.win = exp_winner(failm);
    e.failm = failm;
    sb_q.push_back(e);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic toggle(int n);
    repeat (n) begin
      @(negedge clk);
      bus_rdy = ~bus_rdy;
    end
  endtask

  task automatic pulse_done(logic [N-1:0] mask, logic [N-1:0] failm);
    @(negedge clk);
    bist_done = mask;
    bist_fail = failm;
    @(negedge clk);
    bist_done = '0;
    bist_fail = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    seen = 1'b0;
    bist_done = '0;
    bist_fail = '0;
    idle(3);
    for (int i = 0; i < N; i++) chk("R1 state", 32'(st_of(i)), 32'd0);
    chk("R1 flags", 32'(flags), 32'd0);
    chk("R1 fetch_valid", 32'(fvalid), 32'd0);
    chk("R1 fetch_addr", faddr, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < N; i++) chk("R2 enter self-test", 32'(st_of(i)), 32'd1);
  endtask

  task automatic wait_seen(string req);
    for (int k = 0; k < 400 && !seen; k++) @(negedge clk);
    chk(req, 32'(seen), 32'd1);
  endtask

  // Monitor: pops the expected outcome when every agent is terminal.
  always @(negedge clk) begin
    if (rst_n && !seen && all_final()) begin
      exp_t e;
      seen = 1'b1;
      if (sb_q.size() == 0) begin
        chk("R5 unexpected election", 32'd1, 32'd0);
      end else begin
        e = sb_q.pop_front();
        for (int i = 0; i < N; i++) begin
          if (i == e.win) begin
            chk("R5 winner state", 32'(st_of(i)), 32'd4);
            chk("R5 winner flag", 32'(flags[i]), 32'd1);
          end else begin
            chk(e.win < 0 ? "R9 agent state" : "R6 loser state", 32'(st_of(i)), 32'd5);
            chk(e.win < 0 ? "R9 agent flag" : "R6 loser flag", 32'(flags[i]), 32'd0);
          end
        end
        chk(e.win < 0 ? "R9 fetch_valid" : "R7 fetch_valid", 32'(fvalid), e.win < 0 ? 32'd0 : 32'd1);
        chk("R7 fetch_addr", faddr, e.win < 0 ? 32'd0 : 32'hFFFF_FFF0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL R5 watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [3*N-1:0] saved_st;
    logic [N-1:0]   saved_fl;

    // Case A: self-test gate (R2), largest ID wins (R4, R5).
    set_ids(8'h22, 8'h07, 8'h41, 8'h03);
    do_reset();
    push_exp(4'b0000);
    toggle(4);
    pulse_done(4'b0111, 4'b0000);
    idle(3 * Q);
    for (int i = 0; i < N; i++) chk("R2 held in self-test", 32'(st_of(i)), 32'd1);
    chk("R2 no flag before all done", 32'(flags), 32'd0);
    pulse_done(4'b1000, 4'b0000);
    toggle(5);
    wait_seen("R5 election completes");

    // Persistence after the election (R8).
    saved_st = state;
    saved_fl = flags;
    toggle(10);
    pulse_done(4'b1111, 4'b1111);
    idle(3 * Q);
    chk("R8 states hold", 32'(state), 32'(saved_st));
    chk("R8 flags hold", 32'(flags), 32'(saved_fl));
    chk("R8 fetch holds", faddr, 32'hFFFF_FFF0);

    // Case B: glitch inside the quiet window restarts the count (R3).
    set_ids(8'h90, 8'h11, 8'h35, 8'h6C);
    do_reset();
    push_exp(4'b0000);
    pulse_done(4'b1111, 4'b0000);
    toggle(5);
    idle(Q - 2);
    toggle(2);
    idle(3);
    for (int i = 0; i < N; i++) chk("R3 still waiting after glitch", 32'(st_of(i)), 32'd2);
    chk("R3 no flag during window", 32'(flags), 32'd0);
    wait_seen("R3 election after quiet");

    // Case C: highest-ID agent fails and is excluded (R4, R6).
    set_ids(8'h10, 8'h80, 8'h20, 8'h30);
    do_reset();
    push_exp(4'b0010);
    pulse_done(4'b0011, 4'b0010);
    pulse_done(4'b1100, 4'b0000);
    toggle(3);
    wait_seen("R4 election with failed agent");

    // Case D: every agent fails (R9).
    set_ids(8'h01, 8'h02, 8'h03, 8'h04);
    do_reset();
    push_exp(4'b1111);
    pulse_done(4'b1111, 4'b1111);
    toggle(2);
    wait_seen("R9 election with all failed");
    idle(5);
    chk("R9 fetch stays off", 32'(fvalid), 32'd0);

    // Case E: staggered done pulses, line never toggles, extreme IDs (R4).
    set_ids(8'hFF, 8'h00, 8'hFE, 8'h01);
    do_reset();
    push_exp(4'b0000);
    for (int i = 0; i < N; i++) begin
      pulse_done(N'(1) << i, 4'b0000);
      idle(2);
    end
    wait_seen("R4 index 0 with ID 0xFF wins");

    chk("R5 scoreboard drained", 32'(sb_q.size()), 32'd0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule